// File: doc/BRIEF.md
# Rolling-Shutter Frame Timing Generator

This block produces the line and frame timing for an image sensor whose rows are read one after another. A column counter runs in main-clock cycles across each line. A row counter runs in lines across each frame. From these two counters the block decodes a frame-level sync, a line-level sync, a data-valid window over the programmed output region, and the pixel-array address of the pixel currently being read.

The block also drives the rolling shutter. A second, virtual pointer runs ahead of the read position by the programmed exposure. Each time that pointer reaches the start of an active row, the block issues a one-cycle reset pulse for that row, so every row integrates for exactly the same time. Exposure is given as a coarse count of lines plus a fine count of main clocks. Settings that would reach a full frame are clamped, and the clamp is recorded in a sticky flag.

The register values arrive already activated. A restart request aligns the counters to the start of a new frame.

Top module: `frame_timing_gen`

## Requirements
- R1: While reset is asserted, the row and column counters read 0, `frame_start` is high and `exp_err` is low. After reset is released, the column counter advances.
- R2: The effective line length is the larger of `line_time` and `out_width + 16`. For example, a width of 8 with a line time of 10 gives 24-cycle lines.
- R3: A frame lasts `out_height + vblank` lines. `frame_start` is high for exactly the one cycle in which the row and column are both 0, so the frame period in cycles is the frame line count times the effective line length.
- R4: `data_valid` is high only for columns 0 to `out_width-1` of rows 0 to `out_height-1`. That gives exactly width × height cycles per frame, and the first of them is the `frame_start` cycle.
- R5: `vsync` is high for every cycle of rows 0 to `out_height-1`. In those rows, `hsync` is high for columns 0 to `out_width+7`.
- R6: A cycle with `restart` high makes the row and column counters read 0 in the following cycle, with `frame_start` high.
- R7: While `data_valid` is high, `arr_x` equals `win_x0 + col` and `arr_y` equals `win_y0 + row`, both modulo 2^11. Otherwise both are 0.
- R8: `exp_reset` pulses for one cycle with `exp_row = r` exactly E cycles before the cycle in which row r is read at column 0, where E = `exp_lines` × line length + `exp_clks`. There is one pulse per active row per frame.
- R9: A fine count `exp_clks` that is not less than the effective line length is treated as line length − 1.
- R10: If `exp_lines` is at least the frame line count, the exposure becomes (frame lines − 1) whole lines with a fine count of 0, and `exp_err` is set. Settings below that bound leave `exp_err` low.
- R11: Once set, `exp_err` stays high until reset, even after the exposure setting becomes legal again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Restart frame at row 0, column 0 |
| out_width | input | 11 | Output columns per active row |
| out_height | input | 11 | Active rows per frame |
| win_x0 | input | 11 | Horizontal start of readout window in the array |
| win_y0 | input | 11 | Vertical start of readout window in the array |
| line_time | input | 16 | Requested line length in main clocks |
| vblank | input | 16 | Vertical blanking in lines |
| exp_lines | input | 16 | Exposure, coarse part in lines |
| exp_clks | input | 16 | Exposure, fine part in main clocks |
| vsync | output | 1 | High during active rows |
| hsync | output | 1 | Line sync within active rows |
| data_valid | output | 1 | Output pixel window |
| frame_start | output | 1 | First cycle of each frame |
| row | output | 17 | Current row of the frame |
| col | output | 16 | Current column (clock) of the line |
| arr_x | output | 11 | Array column being read, 0 when invalid |
| arr_y | output | 11 | Array row being read, 0 when invalid |
| exp_reset | output | 1 | Row exposure-reset pulse |
| exp_row | output | 17 | Row addressed by the exposure pointer |
| exp_err | output | 1 | Sticky exposure clamp flag |

## Verification
The assertions assume that the timing inputs change only together with a restart request, so the counters never sit outside a newly shortened line or frame. They also assume that the output height is at least one row. The bench follows both rules: every scenario drives new settings on a falling edge, pulses `restart` immediately afterwards, and uses heights of four rows. Line lengths never drop below 16 cycles, which keeps `frame_start` and `exp_reset` to single-cycle pulses as the checker expects.

// File: rtl/frame_timing_pkg.sv
package frame_timing_pkg;
  localparam int FTG_CNT_W = 16;
  localparam int FTG_SZ_W  = 11;
  localparam int FTG_ROW_W = FTG_CNT_W + 1;

  typedef struct packed {
    logic [FTG_CNT_W-1:0] line_len;
    logic [FTG_ROW_W-1:0] frame_lines;
    logic [FTG_ROW_W-1:0] exp_lines;
    logic [FTG_CNT_W-1:0] exp_fine;
  } ftg_geom_t;
endpackage

// File: rtl/ftg_geometry.sv
module ftg_geometry
  import frame_timing_pkg::*;
#(
  parameter int MIN_HBLANK = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FTG_SZ_W-1:0]  out_width,
  input  logic [FTG_SZ_W-1:0]  out_height,
  input  logic [FTG_CNT_W-1:0] line_time,
  input  logic [FTG_CNT_W-1:0] vblank,
  input  logic [FTG_CNT_W-1:0] exp_lines,
  input  logic [FTG_CNT_W-1:0] exp_clks,
  output ftg_geom_t            geom,
  output logic                 exp_err
);
  localparam int PAD_W = FTG_CNT_W - FTG_SZ_W;

  logic [FTG_CNT_W-1:0] min_line;
  logic [FTG_ROW_W-1:0] lines_ext;
  logic                 too_long;
  logic                 err_q, err_d, err_en;

  // Effective line length and frame length
  always_comb begin
    min_line         = {{PAD_W{1'b0}}, out_width} + FTG_CNT_W'(MIN_HBLANK);
    geom.line_len    = (line_time < min_line) ? min_line : line_time;
    geom.frame_lines = {{(FTG_ROW_W-FTG_SZ_W){1'b0}}, out_height}
                     + {1'b0, vblank};
  end

  // Exposure limiting: coarse part below frame, fine part below one line
  always_comb begin
    lines_ext = {1'b0, exp_lines};
    too_long  = (lines_ext >= geom.frame_lines);
    if (too_long) begin
      geom.exp_lines = geom.frame_lines - FTG_ROW_W'(1);
      geom.exp_fine  = '0;
    end else begin
      geom.exp_lines = lines_ext;
      geom.exp_fine  = (exp_clks >= geom.line_len) ?
                       (geom.line_len - FTG_CNT_W'(1)) : exp_clks;
    end
  end

  always_comb begin
    err_en = too_long & ~err_q;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign exp_err = err_q;
endmodule

// File: rtl/ftg_counters.sv
module ftg_counters
  import frame_timing_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  ftg_geom_t            geom,
  output logic [FTG_ROW_W-1:0] row,
  output logic [FTG_CNT_W-1:0] col
);
  logic [FTG_ROW_W-1:0] row_q, row_d;
  logic [FTG_CNT_W-1:0] col_q, col_d;
  logic                 line_end, frame_end, cnt_en;

  always_comb begin
    line_end  = (col_q >= geom.line_len - FTG_CNT_W'(1));
    frame_end = (row_q >= geom.frame_lines - FTG_ROW_W'(1));
    cnt_en    = 1'b1;
    col_d     = col_q;
    row_d     = row_q;
    if (restart) begin
      col_d = '0;
      row_d = '0;
    end else if (line_end) begin
      col_d = '0;
      row_d = frame_end ? '0 : row_q + FTG_ROW_W'(1);
    end else begin
      col_d = col_q + FTG_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (cnt_en) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign row = row_q;
  assign col = col_q;
endmodule

// File: rtl/ftg_expo_ptr.sv
module ftg_expo_ptr
  import frame_timing_pkg::*;
(
  input  ftg_geom_t            geom,
  input  logic [FTG_SZ_W-1:0]  out_height,
  input  logic [FTG_ROW_W-1:0] row,
  input  logic [FTG_CNT_W-1:0] col,
  output logic                 exp_reset,
  output logic [FTG_ROW_W-1:0] exp_row
);
  logic [FTG_CNT_W:0]   col_sum;
  logic                 carry;
  logic [FTG_CNT_W-1:0] lead_col;
  logic [FTG_ROW_W:0]   row_sum;
  logic [FTG_ROW_W-1:0] lead_row;

  // Lead pointer = read position + exposure, folded modulo the frame
  always_comb begin
    col_sum  = {1'b0, col} + {1'b0, geom.exp_fine};
    carry    = (col_sum >= {1'b0, geom.line_len});
    lead_col = carry ? FTG_CNT_W'(col_sum - {1'b0, geom.line_len})
                     : col_sum[FTG_CNT_W-1:0];
    row_sum  = {1'b0, row} + {1'b0, geom.exp_lines} + (FTG_ROW_W+1)'(carry);
    lead_row = (row_sum >= {1'b0, geom.frame_lines}) ?
               FTG_ROW_W'(row_sum - {1'b0, geom.frame_lines}) :
               row_sum[FTG_ROW_W-1:0];
    exp_row   = lead_row;
    exp_reset = (lead_col == '0) &&
                (lead_row < {{(FTG_ROW_W-FTG_SZ_W){1'b0}}, out_height});
  end
endmodule

// File: rtl/ftg_sync_decode.sv
module ftg_sync_decode
  import frame_timing_pkg::*;
#(
  parameter int MIN_HBLANK = 16
) (
  input  logic [FTG_SZ_W-1:0]  out_width,
  input  logic [FTG_SZ_W-1:0]  out_height,
  input  logic [FTG_SZ_W-1:0]  win_x0,
  input  logic [FTG_SZ_W-1:0]  win_y0,
  input  logic [FTG_ROW_W-1:0] row,
  input  logic [FTG_CNT_W-1:0] col,
  output logic                 vsync,
  output logic                 hsync,
  output logic                 data_valid,
  output logic                 frame_start,
  output logic [FTG_SZ_W-1:0]  arr_x,
  output logic [FTG_SZ_W-1:0]  arr_y
);
  localparam int HS_TAIL = MIN_HBLANK / 2;

  logic active_row;
  logic [FTG_CNT_W-1:0] width_ext;

  always_comb begin
    width_ext   = {{(FTG_CNT_W-FTG_SZ_W){1'b0}}, out_width};
    active_row  = (row < {{(FTG_ROW_W-FTG_SZ_W){1'b0}}, out_height});
    vsync       = active_row;
    hsync       = active_row && (col < width_ext + FTG_CNT_W'(HS_TAIL));
    data_valid  = active_row && (col < width_ext);
    frame_start = (row == '0) && (col == '0);
    arr_x       = data_valid ? (win_x0 + col[FTG_SZ_W-1:0]) : '0;
    arr_y       = data_valid ? (win_y0 + row[FTG_SZ_W-1:0]) : '0;
  end
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import frame_timing_pkg::*;
#(
  parameter int MIN_HBLANK = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic [FTG_SZ_W-1:0]  out_width,
  input  logic [FTG_SZ_W-1:0]  out_height,
  input  logic [FTG_SZ_W-1:0]  win_x0,
  input  logic [FTG_SZ_W-1:0]  win_y0,
  input  logic [FTG_CNT_W-1:0] line_time,
  input  logic [FTG_CNT_W-1:0] vblank,
  input  logic [FTG_CNT_W-1:0] exp_lines,
  input  logic [FTG_CNT_W-1:0] exp_clks,
  output logic                 vsync,
  output logic                 hsync,
  output logic                 data_valid,
  output logic                 frame_start,
  output logic [FTG_ROW_W-1:0] row,
  output logic [FTG_CNT_W-1:0] col,
  output logic [FTG_SZ_W-1:0]  arr_x,
  output logic [FTG_SZ_W-1:0]  arr_y,
  output logic                 exp_reset,
  output logic [FTG_ROW_W-1:0] exp_row,
  output logic                 exp_err
);
  logic      rst_meta, rst_sync_n;
  ftg_geom_t geom;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ftg_geometry #(.MIN_HBLANK(MIN_HBLANK)) u_geom (
    .clk(clk), .rst_n(rst_sync_n),
    .out_width(out_width), .out_height(out_height),
    .line_time(line_time), .vblank(vblank),
    .exp_lines(exp_lines), .exp_clks(exp_clks),
    .geom(geom), .exp_err(exp_err)
  );

  ftg_counters u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart),
    .geom(geom), .row(row), .col(col)
  );

  ftg_expo_ptr u_expo (
    .geom(geom), .out_height(out_height), .row(row), .col(col),
    .exp_reset(exp_reset), .exp_row(exp_row)
  );

  ftg_sync_decode #(.MIN_HBLANK(MIN_HBLANK)) u_dec (
    .out_width(out_width), .out_height(out_height),
    .win_x0(win_x0), .win_y0(win_y0), .row(row), .col(col),
    .vsync(vsync), .hsync(hsync), .data_valid(data_valid),
    .frame_start(frame_start), .arr_x(arr_x), .arr_y(arr_y)
  );
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker
  import frame_timing_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 restart,
  input logic                 vsync,
  input logic                 hsync,
  input logic                 data_valid,
  input logic                 frame_start,
  input logic [FTG_ROW_W-1:0] row,
  input logic [FTG_CNT_W-1:0] col,
  input logic                 exp_reset,
  input logic                 exp_err
);
  // R6: restart lands on row 0, column 0 with a frame start
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (row == '0 && col == '0 && frame_start));

  // R3: the column counter only steps by one or returns to zero
  a_r3_col_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (col != '0 && !$past(restart)) |-> (col == FTG_CNT_W'($past(col) + 1'b1)));

  // R3: frame start is a single-cycle pulse
  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !restart) |=> !frame_start);

  // R4: valid data lies inside both sync windows
  a_r4_valid_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (vsync && hsync));

  // R8: exposure reset is a single-cycle pulse
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_reset && !restart) |=> !exp_reset);

  // R11: error flag never clears outside reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    exp_err |=> exp_err);
endmodule

bind frame_timing_gen ftg_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .restart(restart),
  .vsync(vsync), .hsync(hsync), .data_valid(data_valid),
  .frame_start(frame_start), .row(row), .col(col),
  .exp_reset(exp_reset), .exp_err(exp_err)
);

// File: tb/frame_timing_gen_bench.sv
module frame_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        restart;
  logic [10:0] out_width, out_height, win_x0, win_y0;
  logic [15:0] line_time, vblank, exp_lines, exp_clks;
  logic        vsync, hsync, data_valid, frame_start, exp_reset, exp_err;
  logic [16:0] row, exp_row;
  logic [15:0] col;
  logic [10:0] arr_x, arr_y;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  frame_timing_gen u_frame_timing_gen (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .out_width(out_width), .out_height(out_height),
    .win_x0(win_x0), .win_y0(win_y0),
    .line_time(line_time), .vblank(vblank),
    .exp_lines(exp_lines), .exp_clks(exp_clks),
    .vsync(vsync), .hsync(hsync), .data_valid(data_valid),
    .frame_start(frame_start), .row(row), .col(col),
    .arr_x(arr_x), .arr_y(arr_y),
    .exp_reset(exp_reset), .exp_row(exp_row), .exp_err(exp_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int lt, input int el, input int ec);
    line_time = 16'(lt);
    exp_lines = 16'(el);
    exp_clks  = 16'(ec);
    restart   = 1'b1;
    @(negedge clk);
    restart   = 1'b0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 5000 && !frame_start; i++) @(negedge clk);
  endtask

  task automatic frame_period(output int cyc);
    wait_start();
    @(negedge clk);
    cyc = 1;
    for (int i = 0; i < 5000 && !frame_start; i++) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic exp_gap(input int r, output int gap);
    for (int i = 0; i < 5000 && !(exp_reset && exp_row == 17'(r)); i++) @(negedge clk);
    gap = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      gap++;
      if (row == 17'(r) && col == 16'd0) break;
    end
  endtask

  task automatic t_reset();
    check(row == 0 && col == 0, "R1 counters in reset", col, 0);
    check(frame_start == 1'b1, "R1 frame_start in reset", frame_start, 1);
    check(exp_err == 1'b0, "R1 exp_err in reset", exp_err, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(col != 0, "R1 counting after release", col, 8);
  endtask

  task automatic t_frame_len();
    int c;
    configure(40, 2, 3);
    frame_period(c);
    check(c == 240, "R3 frame period", c, 240);
    configure(10, 2, 3);
    frame_period(c);
    check(c == 144, "R2 line clamp to width+16", c, 144);
  endtask

  task automatic t_windows();
    int dv, hs, vs, ers;
    configure(40, 2, 3);
    wait_start();
    check(data_valid == 1'b1, "R4 valid on frame_start", data_valid, 1);
    dv = 0; hs = 0; vs = 0; ers = 0;
    for (int i = 0; i < 240; i++) begin
      dv += int'(data_valid);
      hs += int'(hsync);
      vs += int'(vsync);
      ers += int'(exp_reset);
      @(negedge clk);
    end
    check(dv == 32, "R4 valid cycles per frame", dv, 32);
    check(hs == 64, "R5 hsync cycles per frame", hs, 64);
    check(vs == 160, "R5 vsync cycles per frame", vs, 160);
    check(ers == 4, "R8 reset pulses per frame", ers, 4);
  endtask

  task automatic t_addr();
    for (int i = 0; i < 1000 && !(row == 1 && col == 3); i++) @(negedge clk);
    check(arr_x == 11'd8 && arr_y == 11'd8, "R7 array address", {arr_x, arr_y}, {11'd8, 11'd8});
    for (int i = 0; i < 1000 && !(row == 1 && col == 20); i++) @(negedge clk);
    check(arr_x == 0 && arr_y == 0, "R7 address zero outside window", {arr_x, arr_y}, 0);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 1000 && !(row == 2 && col == 5); i++) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(row == 0 && col == 0 && frame_start, "R6 restart realigns", {row, col}, 0);
  endtask

  task automatic t_exposure();
    int g;
    configure(40, 2, 3);
    exp_gap(2, g);
    check(g == 83, "R8 exposure lead", g, 83);
    configure(40, 2, 100);
    exp_gap(1, g);
    check(g == 119, "R9 fine count clamp", g, 119);
    configure(40, 5, 0);
    exp_gap(3, g);
    check(g == 200, "R10 longest legal exposure", g, 200);
    check(exp_err == 1'b0, "R10 no flag when legal", exp_err, 0);
    configure(40, 6, 7);
    exp_gap(0, g);
    check(g == 200, "R10 clamp to frame minus one line", g, 200);
    check(exp_err == 1'b1, "R10 flag on clamp", exp_err, 1);
    configure(40, 2, 3);
    exp_gap(2, g);
    check(exp_err == 1'b1, "R11 flag sticky", exp_err, 1);
    check(g == 83, "R11 legal exposure after clamp", g, 83);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0;
    out_width = 11'd8; out_height = 11'd4; win_x0 = 11'd5; win_y0 = 11'd7;
    line_time = 16'd40; vblank = 16'd2; exp_lines = 16'd2; exp_clks = 16'd3;
    repeat (3) @(negedge clk);
    t_reset();
    t_frame_len();
    t_windows();
    t_addr();
    t_restart();
    t_exposure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule